// File: doc/BRIEF.md
# Firmware Table Loader

This block builds a firmware image by walking a chain of records held in a byte-wide source memory. Each record names a word-aligned place in a 64K-word target image, gives a count of 16-bit words, and then carries those words. A single pulse on `start` latches the byte pointer of the first record. The controller then reads record after record and writes every data word to the image through a plain word write port. It stops at the first record whose address is too low to be flash.

The source is read through a synchronous port with one cycle of latency, one byte per read. Words are assembled from two consecutive byte reads, with the lower byte address holding the low byte. A guard limit caps the number of words copied in one walk, so a corrupt chain cannot run away. When the walk ends, a one-cycle `done` pulse reports a clean finish and a one-cycle `error` pulse reports an abnormal stop. `err_code` gives the cause of an abnormal stop, and `entry_count` gives the number of records fully copied.

Top module: `fw_table_loader`

## Requirements
- R1: After reset `busy`, `done`, `error` and `tgt_wr_en` are low, and `entry_count` and `err_code` are zero.
- R2: A `start` pulse while idle latches `entry_ptr` and raises `busy` from the next cycle until the walk ends. A `start` while busy is ignored and does not change the writes.
- R3: A record is a 16-bit target byte address, then a 16-bit word count, then that many data words. Each field is two bytes with the low byte at the lower source address.
- R4: Data word k of a record whose address is A is written to target word address A/2+k, modulo 65536, with the data word on `tgt_wr_data`. Writes appear in source order.
- R5: The next record starts at the record pointer plus 4 plus twice the word count. A record with count 0 writes nothing and the walk continues with the next record.
- R6: A record address below 0x2500 ends the walk. That record writes nothing, `done` pulses for one cycle and `busy` falls in the same cycle.
- R7: An odd record address at or above 0x2500 ends the walk with no write for that record, an `error` pulse and `err_code` = 2'b01.
- R8: At most GUARD_LIMIT words are written in one walk. The data word that would exceed the limit is not written, `error` pulses and `err_code` = 2'b10. On a normal finish `err_code` = 2'b00.
- R9: `entry_count` is the number of records whose address was accepted and whose data was fully written. It is cleared when a walk starts and holds its value while idle.
- R10: Source reads come in pairs at byte addresses p and p+1, one read per cycle. Each walk issues exactly two reads per word fetched, and the terminating word counts as fetched.
- R11: `done` and `error` are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| entry_ptr | input | SRC_AW | Byte pointer of the first record |
| src_rd_en | output | 1 | Source byte read request |
| src_rd_addr | output | SRC_AW | Source byte address |
| src_rd_data | input | 8 | Source byte, valid the cycle after the request |
| tgt_wr_en | output | 1 | Target image word write strobe |
| tgt_wr_addr | output | 16 | Target image word address |
| tgt_wr_data | output | 16 | Target image word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: sentinel reached |
| error | output | 1 | One-cycle pulse: walk aborted |
| err_code | output | 2 | Abort cause: 01 odd address, 10 guard limit |
| entry_count | output | CNT_W | Records fully copied in the last walk |

## Verification
A pointer advanced by the wrong amount shows up within a few cycles, because the next record then decodes from misaligned bytes. The result is a write address or data word that differs from the bench model, a wrong read count, or an early stop. A target counter or byte order fault shows on the first data write of a record. A wrong terminal decision shows in the cycle `done` or `error` pulses, through `err_code`, `entry_count` and the number of writes. A wrong guard count shows as one write too many or too few at the end of the guard test.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ADR,
        W_LEN,
        W_DATA
    } walk_st_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_HI,
        RD_CAP
    } rd_st_e;

    localparam logic [1:0] ERR_NONE  = 2'b00;
    localparam logic [1:0] ERR_ODD   = 2'b01;
    localparam logic [1:0] ERR_GUARD = 2'b10;

endpackage

// File: rtl/fwl_byte_reader.sv
// Assembles one little-endian 16-bit word from two single-cycle-latency
// byte reads. Accepts a request only while idle.
module fwl_byte_reader
    import fwl_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic          busy,
    output logic          word_valid,
    output logic [15:0]   word,
    output logic          src_rd_en,
    output logic [AW-1:0] src_rd_addr,
    input  logic [7:0]    src_rd_data
);

    typedef struct packed {
        rd_st_e        st;
        logic [AW-1:0] base;
        logic [7:0]    lo;
    } rd_t;

    rd_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        src_rd_en   = 1'b0;
        src_rd_addr = r_q.base;
        word_valid  = 1'b0;
        word        = {src_rd_data, r_q.lo};
        case (r_q.st)
            RD_IDLE: begin
                if (req) begin
                    src_rd_en   = 1'b1;
                    src_rd_addr = addr;
                    r_d.base    = addr;
                    r_d.st      = RD_HI;
                end
            end
            RD_HI: begin
                src_rd_en   = 1'b1;
                src_rd_addr = r_q.base + AW'(1);
                r_d.lo      = src_rd_data;
                r_d.st      = RD_CAP;
            end
            RD_CAP: begin
                word_valid = 1'b1;
                r_d.st     = RD_IDLE;
            end
            default: r_d.st = RD_IDLE;
        endcase
    end

    assign busy = (r_q.st != RD_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: RD_IDLE, base: '0, lo: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R10
    hi_byte_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RD_HI) |-> (src_rd_en && src_rd_addr == $past(src_rd_addr) + AW'(1)));

    // R10
    no_read_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !src_rd_en);

endmodule

// File: rtl/fwl_guard.sv
// Counts words copied in one walk and flags when the limit is reached.
module fwl_guard #(
    parameter int LIMIT = 65535
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } g_t;

    g_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (clr) begin
            g_d.cnt = '0;
        end else if (inc && !full) begin
            g_d.cnt = g_q.cnt + CW'(1);
        end
    end

    assign full = (g_q.cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '{cnt: '0};
        end else begin
            g_q <= g_d;
        end
    end

    // R8
    guard_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= CW'(LIMIT));

    // R8
    guard_no_inc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

endmodule

// File: rtl/fw_table_loader.sv
module fw_table_loader
    import fwl_pkg::*;
#(
    parameter int          SRC_AW      = 16,
    parameter int          CNT_W       = 16,
    parameter int          GUARD_LIMIT = 65535,
    parameter logic [15:0] MIN_ADR     = 16'h2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SRC_AW-1:0] entry_ptr,
    output logic              src_rd_en,
    output logic [SRC_AW-1:0] src_rd_addr,
    input  logic [7:0]        src_rd_data,
    output logic              tgt_wr_en,
    output logic [15:0]       tgt_wr_addr,
    output logic [15:0]       tgt_wr_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code,
    output logic [CNT_W-1:0]  entry_count
);

    localparam logic [SRC_AW-1:0] WSTEP = SRC_AW'(2);

    typedef struct packed {
        walk_st_e          st;
        logic              pend;
        logic [SRC_AW-1:0] ptr;
        logic [15:0]       tgt;
        logic [15:0]       remain;
        logic [CNT_W-1:0]  cnt;
        logic              wr_en;
        logic [15:0]       wr_addr;
        logic [15:0]       wr_data;
        logic              done;
        logic              err;
        logic [1:0]        code;
    } w_t;

    w_t w_q, w_d;

    logic        rd_req;
    logic        rd_busy;
    logic        word_valid;
    logic [15:0] word;
    logic        guard_clr;
    logic        guard_inc;
    logic        guard_full;

    fwl_byte_reader #(.AW(SRC_AW)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (rd_req),
        .addr       (w_q.ptr),
        .busy       (rd_busy),
        .word_valid (word_valid),
        .word       (word),
        .src_rd_en  (src_rd_en),
        .src_rd_addr(src_rd_addr),
        .src_rd_data(src_rd_data)
    );

    fwl_guard #(.LIMIT(GUARD_LIMIT)) u_guard (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (guard_clr),
        .inc  (guard_inc),
        .full (guard_full)
    );

    always_comb begin
        w_d       = w_q;
        w_d.wr_en = 1'b0;
        w_d.done  = 1'b0;
        w_d.err   = 1'b0;
        rd_req    = 1'b0;
        guard_clr = 1'b0;
        guard_inc = 1'b0;

        if (w_q.st == W_IDLE) begin
            if (start) begin
                w_d.st    = W_ADR;
                w_d.ptr   = entry_ptr;
                w_d.cnt   = '0;
                w_d.code  = ERR_NONE;
                w_d.pend  = 1'b0;
                guard_clr = 1'b1;
            end
        end else begin
            rd_req = !w_q.pend && !rd_busy;
            if (rd_req) begin
                w_d.pend = 1'b1;
            end
            if (word_valid) begin
                w_d.pend = 1'b0;
                case (w_q.st)
                    W_ADR: begin
                        if (word < MIN_ADR) begin
                            w_d.done = 1'b1;
                            w_d.st   = W_IDLE;
                        end else if (word[0]) begin
                            w_d.err  = 1'b1;
                            w_d.code = ERR_ODD;
                            w_d.st   = W_IDLE;
                        end else begin
                            w_d.tgt = {1'b0, word[15:1]};
                            w_d.ptr = w_q.ptr + WSTEP;
                            w_d.st  = W_LEN;
                        end
                    end
                    W_LEN: begin
                        w_d.ptr = w_q.ptr + WSTEP;
                        if (word == 16'd0) begin
                            w_d.cnt = w_q.cnt + CNT_W'(1);
                            w_d.st  = W_ADR;
                        end else begin
                            w_d.remain = word;
                            w_d.st     = W_DATA;
                        end
                    end
                    W_DATA: begin
                        if (guard_full) begin
                            w_d.err  = 1'b1;
                            w_d.code = ERR_GUARD;
                            w_d.st   = W_IDLE;
                        end else begin
                            guard_inc   = 1'b1;
                            w_d.wr_en   = 1'b1;
                            w_d.wr_addr = w_q.tgt;
                            w_d.wr_data = word;
                            w_d.tgt     = w_q.tgt + 16'd1;
                            w_d.ptr     = w_q.ptr + WSTEP;
                            w_d.remain  = w_q.remain - 16'd1;
                            if (w_q.remain == 16'd1) begin
                                w_d.cnt = w_q.cnt + CNT_W'(1);
                                w_d.st  = W_ADR;
                            end
                        end
                    end
                    default: w_d.st = W_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, pend: 1'b0, ptr: '0, tgt: '0, remain: '0,
                     cnt: '0, wr_en: 1'b0, wr_addr: '0, wr_data: '0,
                     done: 1'b0, err: 1'b0, code: ERR_NONE};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy        = (w_q.st != W_IDLE);
    assign done        = w_q.done;
    assign error       = w_q.err;
    assign err_code    = w_q.code;
    assign entry_count = w_q.cnt;
    assign tgt_wr_en   = w_q.wr_en;
    assign tgt_wr_addr = w_q.wr_addr;
    assign tgt_wr_data = w_q.wr_data;

    // R11
    done_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    error_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    error_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != ERR_NONE && !busy));

    // R2
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_en |-> busy);

    // R9
    count_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(start)) |=> $stable(entry_count) || busy);

    // R10
    no_read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !src_rd_en);

endmodule

// File: tb/fw_table_loader_bench.sv
`timescale 1ns/1ps
module fw_table_loader_bench;

    localparam int AW    = 12;
    localparam int MSIZE = 1 << AW;
    localparam int GLIM  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] entry_ptr = '0;
    logic          src_rd_en;
    logic [AW-1:0] src_rd_addr;
    logic [7:0]    src_rd_data;
    logic          tgt_wr_en;
    logic [15:0]   tgt_wr_addr;
    logic [15:0]   tgt_wr_data;
    logic          busy, done, error;
    logic [1:0]    err_code;
    logic [15:0]   entry_count;

    logic [7:0] mem [0:MSIZE-1];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (src_rd_en) src_rd_data <= mem[src_rd_addr];
    end

    fw_table_loader #(.SRC_AW(AW), .CNT_W(16), .GUARD_LIMIT(GLIM)) u_fw_table_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_ptr(entry_ptr),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .tgt_wr_en(tgt_wr_en), .tgt_wr_addr(tgt_wr_addr), .tgt_wr_data(tgt_wr_data),
        .busy(busy), .done(done), .error(error), .err_code(err_code),
        .entry_count(entry_count)
    );

    // expected walk results
    logic [15:0] exp_a [0:255];
    logic [15:0] exp_d [0:255];
    int exp_n, exp_kind, exp_cnt, exp_reads;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input int p);
        return {mem[(p + 1) % MSIZE], mem[p % MSIZE]};
    endfunction

    task automatic put16(input int p, input logic [15:0] v);
        mem[p % MSIZE]       = v[7:0];
        mem[(p + 1) % MSIZE] = v[15:8];
    endtask

    // kind: 0 sentinel, 1 odd address, 2 guard
    task automatic model_walk(input int p0);
        int p = p0;
        int copied = 0;
        logic [15:0] a, l;
        exp_n = 0; exp_cnt = 0; exp_kind = 0; exp_reads = 0;
        while (1) begin
            a = rd16(p); exp_reads += 2;
            if (a < 16'h2500) begin exp_kind = 0; return; end
            if (a[0]) begin exp_kind = 1; return; end
            l = rd16(p + 2); exp_reads += 2;
            p += 4;
            for (int k = 0; k < int'(l); k++) begin
                exp_reads += 2;
                if (copied == GLIM) begin exp_kind = 2; return; end
                exp_a[exp_n] = 16'((a >> 1) + k);
                exp_d[exp_n] = rd16(p);
                exp_n++; copied++;
                p += 2;
            end
            exp_cnt++;
        end
    endtask

    task automatic run_walk(input int p, input string tag, input bit poke);
        int got = 0, reads = 0, cyc = 0;
        bit fin = 0, phase = 0;
        logic [AW-1:0] lo_addr = '0;
        model_walk(p);
        @(negedge clk); start = 1'b1; entry_ptr = AW'(p);
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
        while (!fin && cyc < 4000) begin
            if (src_rd_en) begin
                reads++;
                if (!phase) begin lo_addr = src_rd_addr; phase = 1; end
                else begin
                    chk(src_rd_addr == lo_addr + AW'(1), "R10", {tag, " read pair"},
                        src_rd_addr, lo_addr + AW'(1));
                    phase = 0;
                end
            end
            if (tgt_wr_en) begin
                if (got < exp_n) begin
                    chk(tgt_wr_addr == exp_a[got], "R4", {tag, " write addr"}, tgt_wr_addr, exp_a[got]);
                    chk(tgt_wr_data == exp_d[got], "R3", {tag, " write data"}, tgt_wr_data, exp_d[got]);
                end else begin
                    chk(0, "R8", {tag, " extra write"}, got, exp_n);
                end
                got++;
            end
            if (done || error) begin
                fin = 1;
                chk(busy == 1'b0, "R6", {tag, " busy at end"}, busy, 0);
                chk(done == (exp_kind == 0), "R6", {tag, " done kind"}, done, exp_kind == 0);
                chk(error == (exp_kind != 0), "R7", {tag, " error kind"}, error, exp_kind != 0);
                chk(err_code == 2'(exp_kind), "R8", {tag, " err_code"}, err_code, exp_kind);
            end else begin
                start = poke && (cyc == 6);
                if (poke) entry_ptr = AW'(p + 3);
                @(negedge clk);
                start = 1'b0;
                cyc++;
            end
        end
        chk(fin, "R2", {tag, " walk ended"}, fin, 1);
        chk(got == exp_n, "R5", {tag, " write count"}, got, exp_n);
        chk(reads == exp_reads, "R10", {tag, " read count"}, reads, exp_reads);
        chk(entry_count == 16'(exp_cnt), "R9", {tag, " entry_count"}, entry_count, exp_cnt);
        @(negedge clk);
        chk(!done && !error, "R11", {tag, " pulse width"}, {done, error}, 0);
        chk(!tgt_wr_en && !src_rd_en, "R6", {tag, " quiet after end"}, {tgt_wr_en, src_rd_en}, 0);
        repeat (3) @(negedge clk);
        chk(entry_count == 16'(exp_cnt), "R9", {tag, " entry_count hold"}, entry_count, exp_cnt);
    endtask

    task automatic build_random(input int base);
        int p = base;
        int nent = $urandom % 5;
        for (int e = 0; e < nent; e++) begin
            int l = $urandom % 7;
            put16(p, 16'(16'h2500 + 2 * ($urandom % ((32'h10000 - 32'h2500) / 2))));
            put16(p + 2, 16'(l));
            p += 4;
            for (int k = 0; k < l; k++) begin
                put16(p, 16'($urandom));
                p += 2;
            end
        end
        put16(p, 16'($urandom % 32'h2500));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MSIZE; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !error && !tgt_wr_en, "R1", "reset outputs",
            {busy, done, error, tgt_wr_en}, 0);
        chk(entry_count == 0 && err_code == 0, "R1", "reset status", {entry_count, err_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !src_rd_en, "R1", "idle after reset", {busy, src_rd_en}, 0);

        // R3 R4 R5: two records then sentinel
        put16(12'h000, 16'h2500); put16(12'h002, 16'd2);
        put16(12'h004, 16'hBEEF); put16(12'h006, 16'h1234);
        put16(12'h008, 16'h3000); put16(12'h00A, 16'd3);
        put16(12'h00C, 16'hA1A2); put16(12'h00E, 16'hB1B2); put16(12'h010, 16'hC1C2);
        put16(12'h012, 16'h0000);
        run_walk(12'h000, "basic", 0);

        // R5 zero length, R6 sentinel boundary 0x24FE
        put16(12'h100, 16'h2500); put16(12'h102, 16'd0);
        put16(12'h104, 16'h8000); put16(12'h106, 16'd1); put16(12'h108, 16'h5A5A);
        put16(12'h10A, 16'hFFFE); put16(12'h10C, 16'd1); put16(12'h10E, 16'h0F0F);
        put16(12'h110, 16'h24FE);
        run_walk(12'h100, "zero_len_boundary", 0);

        // R7 odd address after a good record
        put16(12'h200, 16'h2600); put16(12'h202, 16'd1); put16(12'h204, 16'h7777);
        put16(12'h206, 16'h2701); put16(12'h208, 16'd2);
        run_walk(12'h200, "odd_adr", 0);

        // R8 guard limit
        put16(12'h300, 16'h2500); put16(12'h302, 16'd30);
        put16(12'h340, 16'h4000); put16(12'h342, 16'd20);
        put16(12'h36E, 16'h0000);
        run_walk(12'h300, "guard", 0);

        // R2 start while busy ignored
        run_walk(12'h000, "start_busy", 1);

        // odd byte pointer start
        put16(12'h3A1, 16'h9002); put16(12'h3A3, 16'd2);
        put16(12'h3A5, 16'h0102); put16(12'h3A7, 16'h0304); put16(12'h3A9, 16'h0100);
        run_walk(12'h3A1, "odd_ptr", 0);

        // random chains
        for (int it = 0; it < 20; it++) begin
            int base = 12'h400 + it * 12'h080 + (it % 2) * 5;
            build_random(base);
            run_walk(base, "random", (it % 5) == 3);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule